// File: doc/BRIEF.md
# Operand-Width Adaptive Multiplier Controller

This block multiplies two 32-bit unsigned operands with a datapath whose effort follows the size of the numbers. A start pulse loads both operands. Each operand is sorted into a small, medium or large magnitude class, and the two classes merge into a single precision code. That code sets two things for the rest of the operation. The first is how often the multiplier datapath is allowed to advance: every cycle, every second cycle or every fourth cycle. The second is an encoded supply level, which goes out to an external regulator.

The arithmetic is built from one 8×8 multiplier. Each enabled step adds one shifted partial product into a 64-bit accumulator. Small operands need one step, medium operands need four and large operands need sixteen. The step rate is made by a two-stage toggle chain. The chain is cleared when the precision code is loaded, so the first enable always arrives at a known cycle. A one-cycle done flag marks a finished product. The product then holds until the next accepted start.

Top module: `opwidth_mult_ctrl`

## Requirements
- R1: During and after reset, and until the first start, busyOut, doneOut and clkEnOut are 0, product is 0, precCode is 0 and voltCode is 00.
- R2: Each operand is given a class as follows. A value of 128 or less (zero included) is class 1. A value from 129 to 32768 is class 2. A value above 32768 is class 3.
- R3: precCode carries the higher of the two operand classes as the value 1, 2 or 3.
- R4: voltCode follows precCode: 00 for precCode 1 (1.2 V), 01 for precCode 2 (2.5 V) and 10 for precCode 3 (3.3 V).
- R5: A start that is sampled while idle captures opA and opB at that rising edge, and busyOut rises then. precCode and voltCode take their new values at the following rising edge.
- R6: clkEnOut is high in every cycle of the step phase for precCode 3. For precCode 2 it is high in every second cycle, and for precCode 1 in every fourth cycle, in each case counted from the cycle that follows the code update.
- R7: The operation takes 1, 4 or 16 enabled steps for precCode 1, 2 or 3. doneOut is high for exactly one cycle, in the cycle after the last enable, and busyOut falls at the same edge that ends doneOut.
- R8: product equals opA × opB (64-bit, unsigned) while doneOut is high, and it holds that value until the next start is accepted.
- R9: A start that is asserted while busyOut is high has no effect. The operation continues, and the operands captured earlier set the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Full-rate clock |
| rstN | input | 1 | Asynchronous reset, active low |
| startIn | input | 1 | Start request, sampled at rising edges |
| opA | input | 32 | First unsigned operand |
| opB | input | 32 | Second unsigned operand |
| busyOut | output | 1 | High from operand capture until the end of the done cycle |
| precCode | output | 2 | Precision class of the current or last operation (1, 2, 3) |
| voltCode | output | 2 | Encoded supply-level request |
| clkEnOut | output | 1 | Scaled step enable |
| product | output | 64 | Accumulated product |
| doneOut | output | 1 | One-cycle completion flag |

## Verification
The in-line assertions check four behaviours on every cycle. At the reduced rates, an enable is never followed by another enable in the next cycle. The precision code stays fixed for the whole step phase. done lasts one cycle and is followed by idle. The accumulator equals the full product of the captured operands whenever done is raised. Some behaviours can only be shown by the bench scenarios, which compare against a cycle-accurate model. These are the class boundaries at 128/129 and 32768/32769, the rule that the larger class wins for mixed operand sizes, the exact phase of the first enable, and the step counts. The scenarios also show that a start during a busy operation is dropped.

// File: rtl/omcPkg.sv
package omcPkg;
  localparam int DATA_W  = 32;
  localparam int BYTE_W  = 8;
  localparam int N_BYTES = DATA_W / BYTE_W;
  localparam int SEL_W   = $clog2(N_BYTES);
  localparam int STEP_W  = 2 * SEL_W;
  localparam int PROD_W  = 2 * DATA_W;

  typedef enum logic [1:0] {
    PREC_NONE = 2'd0,
    PREC_8    = 2'd1,
    PREC_16   = 2'd2,
    PREC_32   = 2'd3
  } precT;

  typedef struct packed {
    logic             capture;
    logic             step;
    logic             fin;
    logic [SEL_W-1:0] aSel;
    logic [SEL_W-1:0] bSel;
  } dpStrobeT;

  function automatic logic [1:0] voltOf(precT p);
    case (p)
      PREC_16: return 2'b01;
      PREC_32: return 2'b10;
      default: return 2'b00;
    endcase
  endfunction
endpackage

// File: rtl/omcScan.sv
module omcScan
  import omcPkg::*;
(
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output precT              code
);
  localparam logic [BYTE_W:0]   LIM_SMALL = (BYTE_W + 1)'(1) << (BYTE_W - 1);
  localparam logic [2*BYTE_W:0] LIM_MID   = (2 * BYTE_W + 1)'(1) << (2 * BYTE_W - 1);

  logic [1:0][DATA_W-1:0] ops;
  precT cls [2];

  assign ops = {opB, opA};

  for (genvar g = 0; g < 2; g++) begin : g_opnd
    logic [N_BYTES-1:0] byteNz;
    for (genvar k = 0; k < N_BYTES; k++) begin : g_byte
      assign byteNz[k] = |ops[g][k*BYTE_W +: BYTE_W];
    end
    logic aboveFirst, aboveSecond;
    assign aboveFirst  = |byteNz[N_BYTES-1:1];
    assign aboveSecond = |byteNz[N_BYTES-1:2];
    always_comb begin
      if (!aboveFirst && ({1'b0, ops[g][BYTE_W-1:0]} <= LIM_SMALL))
        cls[g] = PREC_8;
      else if (!aboveSecond && ({1'b0, ops[g][2*BYTE_W-1:0]} <= LIM_MID))
        cls[g] = PREC_16;
      else
        cls[g] = PREC_32;
    end
  end

  assign code = (cls[0] > cls[1]) ? cls[0] : cls[1];
endmodule

// File: rtl/omcCtrl.sv
module omcCtrl
  import omcPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  precT       scanCode,
  output dpStrobeT   strb,
  output logic       busy,
  output logic       done,
  output logic       clkEn,
  output precT       code,
  output logic [1:0] volt
);
  typedef enum logic [1:0] {ST_IDLE, ST_SCAN, ST_RUN, ST_FIN} stateT;

  stateT             state;
  logic              tgl0, tgl1;
  logic [STEP_W-1:0] stepCnt;
  logic [STEP_W-1:0] lastStep;
  logic              tick;

  always_comb begin
    unique case (code)
      PREC_32: tick = 1'b1;
      PREC_16: tick = tgl0;
      default: tick = tgl0 & tgl1;
    endcase
    tick = tick && (state == ST_RUN);
  end

  always_comb begin
    unique case (code)
      PREC_32: lastStep = '1;
      PREC_16: lastStep = STEP_W'(3);
      default: lastStep = '0;
    endcase
  end

  always_comb begin
    strb         = '0;
    strb.capture = (state == ST_IDLE) && start;
    strb.step    = tick;
    strb.fin     = (state == ST_FIN);
    unique case (code)
      PREC_32: begin
        strb.aSel = stepCnt[SEL_W-1:0];
        strb.bSel = stepCnt[STEP_W-1:SEL_W];
      end
      PREC_16: begin
        strb.aSel = SEL_W'(stepCnt[0]);
        strb.bSel = SEL_W'(stepCnt[1]);
      end
      default: begin
        strb.aSel = '0;
        strb.bSel = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      code    <= PREC_NONE;
      volt    <= 2'b00;
      tgl0    <= 1'b0;
      tgl1    <= 1'b0;
      stepCnt <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (start) state <= ST_SCAN;
        ST_SCAN: begin
          code    <= scanCode;
          volt    <= voltOf(scanCode);
          tgl0    <= 1'b0;
          tgl1    <= 1'b0;
          stepCnt <= '0;
          state   <= ST_RUN;
        end
        ST_RUN: begin
          tgl0 <= ~tgl0;
          tgl1 <= tgl1 ^ tgl0;
          if (tick) begin
            if (stepCnt == lastStep) state <= ST_FIN;
            else stepCnt <= stepCnt + STEP_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy  = (state != ST_IDLE);
  assign done  = (state == ST_FIN);
  assign clkEn = tick;

  // R6
  reduced_rate_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (code != PREC_32) && clkEn |=> !clkEn);

  // R5
  code_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN) && ($past(state) == ST_RUN) |-> $stable(code));

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done && !busy);
endmodule

// File: rtl/omcPath.sv
module omcPath
  import omcPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobeT          strb,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic [DATA_W-1:0] aReg,
  output logic [DATA_W-1:0] bReg,
  output logic [PROD_W-1:0] product
);
  logic [BYTE_W-1:0]   aByte, bByte;
  logic [2*BYTE_W-1:0] partial;
  logic [SEL_W:0]      posSum;
  logic [PROD_W-1:0]   shifted;
  logic [PROD_W-1:0]   acc;

  assign aByte   = aReg[strb.aSel*BYTE_W +: BYTE_W];
  assign bByte   = bReg[strb.bSel*BYTE_W +: BYTE_W];
  assign partial = aByte * bByte;
  assign posSum  = {1'b0, strb.aSel} + {1'b0, strb.bSel};
  assign shifted = PROD_W'(partial) << (int'(posSum) * BYTE_W);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      aReg <= '0;
      bReg <= '0;
      acc  <= '0;
    end else if (strb.capture) begin
      aReg <= opA;
      bReg <= opB;
      acc  <= '0;
    end else if (strb.step) begin
      acc <= acc + shifted;
    end
  end

  assign product = acc;

  // R8
  full_product_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.fin |-> acc == ({{DATA_W{1'b0}}, aReg} * {{DATA_W{1'b0}}, bReg}));
endmodule

// File: rtl/opwidth_mult_ctrl.sv
module opwidth_mult_ctrl
  import omcPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              startIn,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic              busyOut,
  output logic [1:0]        precCode,
  output logic [1:0]        voltCode,
  output logic              clkEnOut,
  output logic [PROD_W-1:0] product,
  output logic              doneOut
);
  dpStrobeT          strb;
  logic [DATA_W-1:0] aReg, bReg;
  precT              scanCode, codeQ;

  omcPath u_path (
    .clk(clk), .rstN(rstN), .strb(strb), .opA(opA), .opB(opB),
    .aReg(aReg), .bReg(bReg), .product(product)
  );

  omcScan u_scan (.opA(aReg), .opB(bReg), .code(scanCode));

  omcCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(startIn), .scanCode(scanCode),
    .strb(strb), .busy(busyOut), .done(doneOut), .clkEn(clkEnOut),
    .code(codeQ), .volt(voltCode)
  );

  assign precCode = codeQ;

  // R4
  volt_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (precCode != 2'd0) |-> (voltCode == precCode - 2'd1));

  // R9
  busy_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    busyOut && !doneOut && startIn |=> busyOut && $stable(aReg) && $stable(bReg));
endmodule

// File: tb/opwidth_mult_ctrl_bench.sv
`timescale 1ns/1ps
module opwidth_mult_ctrl_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startIn = 1'b0;
  logic [31:0] opA = '0, opB = '0;
  logic        busyOut, clkEnOut, doneOut;
  logic [1:0]  precCode, voltCode;
  logic [63:0] product;

  int checks = 0;
  int errors = 0;

  opwidth_mult_ctrl u_opwidth_mult_ctrl (
    .clk(clk), .rstN(rstN), .startIn(startIn), .opA(opA), .opB(opB),
    .busyOut(busyOut), .precCode(precCode), .voltCode(voltCode),
    .clkEnOut(clkEnOut), .product(product), .doneOut(doneOut)
  );

  always #2.5 clk = ~clk;

  // behavioural reference: 0 idle, 1 load, 2 stepping, 3 finished
  int          mState = 0;
  int          mCode = 0;
  int          mRun = 0;
  int          mSteps = 0;
  logic [63:0] mA = '0, mB = '0, mProd = '0;
  logic        pS = 1'b0;
  logic [31:0] pA = '0, pB = '0;

  function automatic int classOf(logic [63:0] v);
    if (v <= 64'd128) return 1;
    if (v <= 64'd32768) return 2;
    return 3;
  endfunction

  function automatic int ratioOf(int c);
    return (c == 3) ? 1 : (c == 2) ? 2 : 4;
  endfunction

  function automatic int stepsOf(int c);
    return (c == 3) ? 16 : (c == 2) ? 4 : 1;
  endfunction

  task automatic check(bit ok, string tag, longint unsigned act, longint unsigned exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rstN) begin
      mState = 0; mCode = 0; mRun = 0; mSteps = 0;
      mA = '0; mB = '0; mProd = '0;
    end else begin
      case (mState)
        0: if (pS) begin mA = {32'd0, pA}; mB = {32'd0, pB}; mState = 1; end
        1: begin
          mCode = (classOf(mA) > classOf(mB)) ? classOf(mA) : classOf(mB);
          mRun = 0; mSteps = 0; mState = 2;
        end
        2: begin
          if ((mRun + 1) % ratioOf(mCode) == 0) mSteps++;
          if (mSteps == stepsOf(mCode)) begin
            mState = 3; mProd = mA * mB;
          end else mRun++;
        end
        default: mState = 0;
      endcase
      check(busyOut == (mState != 0), "R7 busy", busyOut, mState != 0);
      check(doneOut == (mState == 3), "R7 done", doneOut, mState == 3);
      check(clkEnOut == (mState == 2 && (mRun + 1) % ratioOf(mCode) == 0),
            "R6 enable", clkEnOut, mState == 2 && (mRun + 1) % ratioOf(mCode) == 0);
      check(precCode == 2'(mCode), "R5 precCode", precCode, mCode);
      check(voltCode == ((mCode == 0) ? 2'd0 : 2'(mCode - 1)), "R4 voltCode",
            voltCode, (mCode == 0) ? 0 : mCode - 1);
      if (mState == 0 || mState == 3)
        check(product == mProd, "R8 product", product, mProd);
    end
    pS = startIn; pA = opA; pB = opB;
  end

  task automatic runOp(logic [31:0] a, logic [31:0] b, int expCode);
    @(posedge clk); #1;
    opA = a; opB = b; startIn = 1'b1;
    @(posedge clk); #1;
    startIn = 1'b0; opA = ~a; opB = ~b;
    @(negedge clk);
    while (!doneOut && checks < 1000000) @(negedge clk);
    check(product == {32'd0, a} * {32'd0, b}, "R8 final product", product, {32'd0, a} * {32'd0, b});
    check(precCode == 2'(expCode), "R2 R3 class", precCode, expCode);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values
    check(busyOut == 0 && doneOut == 0 && clkEnOut == 0, "R1 flags",
          {busyOut, doneOut, clkEnOut}, 0);
    check(product == 0 && precCode == 0 && voltCode == 0, "R1 data",
          {precCode, voltCode}, 0);
    @(posedge clk); #1 rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(busyOut == 0 && product == 0, "R1 idle after reset", busyOut, 0);

    runOp(32'd23, 32'd10, 1);
    runOp(32'd128, 32'd0, 1);          // R2 upper edge of class 1, zero
    runOp(32'd129, 32'd5, 2);          // R2 lower edge of class 2
    runOp(32'd6374, 32'd99, 2);
    runOp(32'd32768, 32'd32768, 2);    // R2 upper edge of class 2
    runOp(32'd32769, 32'd1, 3);        // R2 lower edge of class 3
    runOp(32'd5, 32'd70000, 3);        // R3 mixed, larger wins
    runOp(32'd300, 32'd7, 2);          // R3 mixed 16 by 8
    runOp(32'd2678346, 32'd1500058, 3);
    runOp(32'hFFFF_FFFF, 32'hFFFF_FFFF, 3);

    // R9: a start during a busy operation is dropped
    @(posedge clk); #1;
    opA = 32'd1000; opB = 32'd3000; startIn = 1'b1;
    @(posedge clk); #1;
    startIn = 1'b0;
    repeat (3) @(posedge clk);
    #1 opA = 32'h0123_4567; opB = 32'h89AB_CDEF; startIn = 1'b1;
    @(posedge clk); #1 startIn = 1'b0;
    @(negedge clk);
    while (!doneOut) @(negedge clk);
    check(product == 64'd3000000, "R9 ignored start product", product, 64'd3000000);
    check(precCode == 2'd2, "R9 ignored start class", precCode, 2);
    repeat (3) @(negedge clk);
    check(busyOut == 0, "R9 no second run", busyOut, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule